// File: doc/BRIEF.md
# Physical Register Free Tracker

This block decides when each physical register of an out-of-order core may go back to the rename free pool. It is meant for a core that can retire instructions before they finish. For every register it keeps a busy flag, a count of pending references and a count of blocks. A register counts as free only when the flag is clear and both counts are zero. A register can therefore outlive its architectural replacement. This happens while retired but unfinished instructions still read it, or while a checkpoint or a waiting store pins it.

Each cycle the block takes register identifiers from the rename allocator, the commit stage, the writeback of instructions that retired early, the checkpoint logic and the store buffer. Checkpoint creation and release arrive as bulk masks over the whole register file. All events that touch the same counter in one cycle are added together and applied in a single update. The result is a free vector with one bit per register and the index of the lowest free register. The vector and the index reflect the state after the previous clock edge.

Top module: `prf_free_tracker`

## Requirements
- R1: After synchronous reset every register is free: `free_vec` is all ones, `free_any` is 1 and `free_lowest` is 0.
- R2: Bit i of `free_vec` is 1 exactly when register i has its busy flag clear, a reference count of zero and a block count of zero. It shows the state written at the most recent clock edge.
- R3: An allocation sets the busy flag of `alloc_preg`. Any commit with `cmt_old_valid` clears the busy flag of `cmt_old_dst`. If both hit the same register, the set wins.
- R4: A normal commit (`cmt_virtual`=0) adds 1 to the reference count of `cmt_dst`. When `cmt_old_valid` is set, it subtracts 1 from the reference count of `cmt_old_dst`.
- R5: A virtual commit (`cmt_virtual`=1) adds 1 to the reference count of `cmt_dst` and of each valid source. It leaves the reference count of the old destination unchanged.
- R6: A writeback of a virtually committed instruction subtracts 1 from the reference count of its old destination (when `wb_old_valid`) and of each valid source.
- R7: Checkpoint creation adds 1 to the block count of every register whose bit is set in `ckpt_mask`, and adds 1 more to `ckpt_dst`.
- R8: A checkpoint release subtracts 1 from the block count of every register whose bit is set in `rel_mask`.
- R9: A store block adds 1 to the block count of `st_block_preg`. A store unblock subtracts 1 from the block count of `st_unblock_preg`.
- R10: Several events that reach the same counter in one cycle are summed, for example a source equal to the destination, or a checkpoint destination that is also in the mask.
- R11: Each count is 4 bits wide (0 to 15). A count driven to 15 and then back to 0 behaves correctly, and neither count may underflow or overflow.
- R12: `free_lowest` is the lowest index with a set `free_vec` bit. When no register is free, `free_any` is 0 and `free_lowest` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Rename allocates a register |
| alloc_preg | input | 7 | Allocated register |
| cmt_valid | input | 1 | An instruction retires this cycle |
| cmt_virtual | input | 1 | The retirement is virtual (instruction not finished) |
| cmt_dst | input | 7 | Destination register of the retiring instruction |
| cmt_old_valid | input | 1 | The retiring instruction replaces a mapping |
| cmt_old_dst | input | 7 | Register previously mapped to the destination |
| cmt_src0_valid | input | 1 | First source present |
| cmt_src0 | input | 7 | First source register |
| cmt_src1_valid | input | 1 | Second source present |
| cmt_src1 | input | 7 | Second source register |
| wb_valid | input | 1 | A virtually retired instruction writes back |
| wb_old_valid | input | 1 | That instruction has an old destination |
| wb_old_dst | input | 7 | Its old destination |
| wb_src0_valid | input | 1 | First source present |
| wb_src0 | input | 7 | First source register |
| wb_src1_valid | input | 1 | Second source present |
| wb_src1 | input | 7 | Second source register |
| ckpt_valid | input | 1 | A checkpoint is created |
| ckpt_mask | input | 128 | Registers in the committed map at checkpoint time |
| ckpt_dst | input | 7 | Destination of the checkpointing instruction |
| rel_valid | input | 1 | Checkpoint blocks are released |
| rel_mask | input | 128 | Registers to unblock |
| st_block_valid | input | 1 | A store pins its value register |
| st_block_preg | input | 7 | Value register of that store |
| st_unblock_valid | input | 1 | A store's pin is removed |
| st_unblock_preg | input | 7 | Register to unpin |
| free_vec | output | 128 | One bit per register, 1 when free |
| free_any | output | 1 | At least one register is free |
| free_lowest | output | 7 | Lowest free register index |

## Verification
The assertions rely on three properties of the inputs. The allocator only hands out a register that `free_vec` currently shows as free. No event pattern drives a count below 0 or above 15. A register's busy flag is set and cleared through the allocation and commit ports only. The random stimulus follows a shadow model of every register. Before each cycle it works out the next counts and keeps only legal candidates: it draws allocation targets from the model's free set, draws old destinations and releases from registers whose counts are above zero, and idles the cycle when no legal draw is found. The directed sequences drive one count to its 15 ceiling, and they make a destination collide with a source or with a checkpoint mask bit.

// File: rtl/prf_trk_pkg.sv
package prf_trk_pkg;

    localparam int CNT_W   = 4;
    localparam int DELTA_W = 3;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [DELTA_W-1:0] delta_t;

    typedef struct packed {
        logic busy;
        cnt_t refs;
        cnt_t blks;
    } preg_state_t;

    function automatic delta_t hit(logic v, logic [31:0] a, logic [31:0] idx);
        return (v && (a == idx)) ? delta_t'(1) : delta_t'(0);
    endfunction

endpackage

// File: rtl/prf_event_decode.sv
module prf_event_decode
    import prf_trk_pkg::*;
#(
    parameter int NUM_PREGS = 128,
    localparam int PW = $clog2(NUM_PREGS)
) (
    input  logic                              alloc_valid,
    input  logic [PW-1:0]                     alloc_preg,
    input  logic                              cmt_valid,
    input  logic                              cmt_virtual,
    input  logic [PW-1:0]                     cmt_dst,
    input  logic                              cmt_old_valid,
    input  logic [PW-1:0]                     cmt_old_dst,
    input  logic                              cmt_src0_valid,
    input  logic [PW-1:0]                     cmt_src0,
    input  logic                              cmt_src1_valid,
    input  logic [PW-1:0]                     cmt_src1,
    input  logic                              wb_valid,
    input  logic                              wb_old_valid,
    input  logic [PW-1:0]                     wb_old_dst,
    input  logic                              wb_src0_valid,
    input  logic [PW-1:0]                     wb_src0,
    input  logic                              wb_src1_valid,
    input  logic [PW-1:0]                     wb_src1,
    input  logic                              ckpt_valid,
    input  logic [NUM_PREGS-1:0]              ckpt_mask,
    input  logic [PW-1:0]                     ckpt_dst,
    input  logic                              rel_valid,
    input  logic [NUM_PREGS-1:0]              rel_mask,
    input  logic                              st_block_valid,
    input  logic [PW-1:0]                     st_block_preg,
    input  logic                              st_unblock_valid,
    input  logic [PW-1:0]                     st_unblock_preg,
    output logic [NUM_PREGS-1:0]              busy_set,
    output logic [NUM_PREGS-1:0]              busy_clr,
    output logic [NUM_PREGS-1:0][DELTA_W-1:0] ref_inc,
    output logic [NUM_PREGS-1:0][DELTA_W-1:0] ref_dec,
    output logic [NUM_PREGS-1:0][DELTA_W-1:0] blk_inc,
    output logic [NUM_PREGS-1:0][DELTA_W-1:0] blk_dec
);

    logic cmt_norm, cmt_virt;
    assign cmt_norm = cmt_valid && !cmt_virtual;
    assign cmt_virt = cmt_valid &&  cmt_virtual;

    for (genvar i = 0; i < NUM_PREGS; i++) begin : g_reg
        assign busy_set[i] = hit(alloc_valid, 32'(alloc_preg), i) != '0;
        assign busy_clr[i] = hit(cmt_valid && cmt_old_valid, 32'(cmt_old_dst), i) != '0;

        assign ref_inc[i] = hit(cmt_valid, 32'(cmt_dst), i)
                          + hit(cmt_virt && cmt_src0_valid, 32'(cmt_src0), i)
                          + hit(cmt_virt && cmt_src1_valid, 32'(cmt_src1), i);

        assign ref_dec[i] = hit(cmt_norm && cmt_old_valid, 32'(cmt_old_dst), i)
                          + hit(wb_valid && wb_old_valid, 32'(wb_old_dst), i)
                          + hit(wb_valid && wb_src0_valid, 32'(wb_src0), i)
                          + hit(wb_valid && wb_src1_valid, 32'(wb_src1), i);

        assign blk_inc[i] = delta_t'(ckpt_valid && ckpt_mask[i])
                          + hit(ckpt_valid, 32'(ckpt_dst), i)
                          + hit(st_block_valid, 32'(st_block_preg), i);

        assign blk_dec[i] = delta_t'(rel_valid && rel_mask[i])
                          + hit(st_unblock_valid, 32'(st_unblock_preg), i);
    end

endmodule

// File: rtl/prf_entry.sv
module prf_entry
    import prf_trk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   busy_set,
    input  logic   busy_clr,
    input  delta_t ref_inc,
    input  delta_t ref_dec,
    input  delta_t blk_inc,
    input  delta_t blk_dec,
    output logic   is_free
);

    localparam int WW = CNT_W + 2;

    preg_state_t st_q, st_d;
    logic [WW-1:0] ref_sum, ref_nxt, blk_sum, blk_nxt;

    assign ref_sum = WW'(st_q.refs) + WW'(ref_inc);
    assign ref_nxt = ref_sum - WW'(ref_dec);
    assign blk_sum = WW'(st_q.blks) + WW'(blk_inc);
    assign blk_nxt = blk_sum - WW'(blk_dec);

    always_comb begin
        st_d      = st_q;
        st_d.refs = ref_nxt[CNT_W-1:0];
        st_d.blks = blk_nxt[CNT_W-1:0];
        if (busy_clr) st_d.busy = 1'b0;
        if (busy_set) st_d.busy = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign is_free = !st_q.busy && (st_q.refs == '0) && (st_q.blks == '0);

    a_r3_alloc_sets_busy: assert property (@(posedge clk) disable iff (rst)
        busy_set |=> st_q.busy);
    a_r3_replace_clears_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_clr && !busy_set) |=> !st_q.busy);
    a_r2_idle_holds_state: assert property (@(posedge clk) disable iff (rst)
        (!busy_set && !busy_clr && ref_inc == '0 && ref_dec == '0 &&
         blk_inc == '0 && blk_dec == '0) |=> $stable(st_q));
    a_r11_ref_no_underflow: assert property (@(posedge clk) disable iff (rst)
        ref_sum >= WW'(ref_dec));
    a_r11_ref_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (ref_sum >= WW'(ref_dec)) |-> (ref_nxt <= WW'(CNT_MAX)));
    a_r11_blk_no_underflow: assert property (@(posedge clk) disable iff (rst)
        blk_sum >= WW'(blk_dec));
    a_r11_blk_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (blk_sum >= WW'(blk_dec)) |-> (blk_nxt <= WW'(CNT_MAX)));

endmodule

// File: rtl/prf_lowest_pick.sv
module prf_lowest_pick #(
    parameter int NUM_PREGS = 128,
    localparam int PW = $clog2(NUM_PREGS)
) (
    input  logic [NUM_PREGS-1:0] vec,
    output logic                 any,
    output logic [PW-1:0]        idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_PREGS - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = PW'(i);
            end
        end
    end

endmodule

// File: rtl/prf_free_tracker.sv
module prf_free_tracker
    import prf_trk_pkg::*;
#(
    parameter int NUM_PREGS = 128,
    localparam int PW = $clog2(NUM_PREGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_valid,
    input  logic [PW-1:0]        alloc_preg,
    input  logic                 cmt_valid,
    input  logic                 cmt_virtual,
    input  logic [PW-1:0]        cmt_dst,
    input  logic                 cmt_old_valid,
    input  logic [PW-1:0]        cmt_old_dst,
    input  logic                 cmt_src0_valid,
    input  logic [PW-1:0]        cmt_src0,
    input  logic                 cmt_src1_valid,
    input  logic [PW-1:0]        cmt_src1,
    input  logic                 wb_valid,
    input  logic                 wb_old_valid,
    input  logic [PW-1:0]        wb_old_dst,
    input  logic                 wb_src0_valid,
    input  logic [PW-1:0]        wb_src0,
    input  logic                 wb_src1_valid,
    input  logic [PW-1:0]        wb_src1,
    input  logic                 ckpt_valid,
    input  logic [NUM_PREGS-1:0] ckpt_mask,
    input  logic [PW-1:0]        ckpt_dst,
    input  logic                 rel_valid,
    input  logic [NUM_PREGS-1:0] rel_mask,
    input  logic                 st_block_valid,
    input  logic [PW-1:0]        st_block_preg,
    input  logic                 st_unblock_valid,
    input  logic [PW-1:0]        st_unblock_preg,
    output logic [NUM_PREGS-1:0] free_vec,
    output logic                 free_any,
    output logic [PW-1:0]        free_lowest
);

    logic [NUM_PREGS-1:0]              busy_set, busy_clr;
    logic [NUM_PREGS-1:0][DELTA_W-1:0] ref_inc, ref_dec, blk_inc, blk_dec;

    prf_event_decode #(.NUM_PREGS(NUM_PREGS)) u_decode (
        .alloc_valid     (alloc_valid),
        .alloc_preg      (alloc_preg),
        .cmt_valid       (cmt_valid),
        .cmt_virtual     (cmt_virtual),
        .cmt_dst         (cmt_dst),
        .cmt_old_valid   (cmt_old_valid),
        .cmt_old_dst     (cmt_old_dst),
        .cmt_src0_valid  (cmt_src0_valid),
        .cmt_src0        (cmt_src0),
        .cmt_src1_valid  (cmt_src1_valid),
        .cmt_src1        (cmt_src1),
        .wb_valid        (wb_valid),
        .wb_old_valid    (wb_old_valid),
        .wb_old_dst      (wb_old_dst),
        .wb_src0_valid   (wb_src0_valid),
        .wb_src0         (wb_src0),
        .wb_src1_valid   (wb_src1_valid),
        .wb_src1         (wb_src1),
        .ckpt_valid      (ckpt_valid),
        .ckpt_mask       (ckpt_mask),
        .ckpt_dst        (ckpt_dst),
        .rel_valid       (rel_valid),
        .rel_mask        (rel_mask),
        .st_block_valid  (st_block_valid),
        .st_block_preg   (st_block_preg),
        .st_unblock_valid(st_unblock_valid),
        .st_unblock_preg (st_unblock_preg),
        .busy_set        (busy_set),
        .busy_clr        (busy_clr),
        .ref_inc         (ref_inc),
        .ref_dec         (ref_dec),
        .blk_inc         (blk_inc),
        .blk_dec         (blk_dec)
    );

    for (genvar i = 0; i < NUM_PREGS; i++) begin : g_entry
        prf_entry u_entry (
            .clk     (clk),
            .rst     (rst),
            .busy_set(busy_set[i]),
            .busy_clr(busy_clr[i]),
            .ref_inc (ref_inc[i]),
            .ref_dec (ref_dec[i]),
            .blk_inc (blk_inc[i]),
            .blk_dec (blk_dec[i]),
            .is_free (free_vec[i])
        );
    end

    prf_lowest_pick #(.NUM_PREGS(NUM_PREGS)) u_pick (
        .vec(free_vec),
        .any(free_any),
        .idx(free_lowest)
    );

    a_r12_lowest_is_free: assert property (@(posedge clk) disable iff (rst)
        free_any |-> free_vec[free_lowest]);
    a_r12_none_free_zero: assert property (@(posedge clk) disable iff (rst)
        !free_any |-> (free_lowest == '0 && free_vec == '0));
    a_r3_alloc_only_free: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> free_vec[alloc_preg]);

endmodule

// File: tb/test_prf_free_tracker.sv
`timescale 1ns/1ps
module test_prf_free_tracker;

    localparam int N    = 128;
    localparam int PW   = 7;
    localparam int CMAX = 15;

    logic clk = 1'b0;
    logic rst;
    logic alloc_valid; logic [PW-1:0] alloc_preg;
    logic cmt_valid, cmt_virtual, cmt_old_valid, cmt_src0_valid, cmt_src1_valid;
    logic [PW-1:0] cmt_dst, cmt_old_dst, cmt_src0, cmt_src1;
    logic wb_valid, wb_old_valid, wb_src0_valid, wb_src1_valid;
    logic [PW-1:0] wb_old_dst, wb_src0, wb_src1;
    logic ckpt_valid; logic [N-1:0] ckpt_mask; logic [PW-1:0] ckpt_dst;
    logic rel_valid;  logic [N-1:0] rel_mask;
    logic st_block_valid, st_unblock_valid; logic [PW-1:0] st_block_preg, st_unblock_preg;
    logic [N-1:0] free_vec; logic free_any; logic [PW-1:0] free_lowest;

    int checks = 0, failures = 0;
    int busy_m[N], ref_m[N], blk_m[N];
    int nbusy[N], nref[N], nblk[N];

    always #2.5 clk = ~clk;

    prf_free_tracker i_prf_free_tracker (.*);

    function automatic bit mfree(int i);
        return busy_m[i] == 0 && ref_m[i] == 0 && blk_m[i] == 0;
    endfunction

    task automatic idle_inputs();
        alloc_valid = 0; alloc_preg = '0;
        cmt_valid = 0; cmt_virtual = 0; cmt_dst = '0; cmt_old_valid = 0; cmt_old_dst = '0;
        cmt_src0_valid = 0; cmt_src0 = '0; cmt_src1_valid = 0; cmt_src1 = '0;
        wb_valid = 0; wb_old_valid = 0; wb_old_dst = '0;
        wb_src0_valid = 0; wb_src0 = '0; wb_src1_valid = 0; wb_src1 = '0;
        ckpt_valid = 0; ckpt_mask = '0; ckpt_dst = '0;
        rel_valid = 0; rel_mask = '0;
        st_block_valid = 0; st_block_preg = '0; st_unblock_valid = 0; st_unblock_preg = '0;
    endtask

    task automatic predict(output bit ok);
        for (int i = 0; i < N; i++) begin
            nbusy[i] = busy_m[i]; nref[i] = ref_m[i]; nblk[i] = blk_m[i];
        end
        if (cmt_valid) begin
            nref[cmt_dst]++;
            if (cmt_virtual) begin
                if (cmt_src0_valid) nref[cmt_src0]++;
                if (cmt_src1_valid) nref[cmt_src1]++;
            end
            if (cmt_old_valid) begin
                nbusy[cmt_old_dst] = 0;
                if (!cmt_virtual) nref[cmt_old_dst]--;
            end
        end
        if (alloc_valid) nbusy[alloc_preg] = 1;
        if (wb_valid) begin
            if (wb_old_valid)  nref[wb_old_dst]--;
            if (wb_src0_valid) nref[wb_src0]--;
            if (wb_src1_valid) nref[wb_src1]--;
        end
        if (ckpt_valid) begin
            for (int i = 0; i < N; i++) if (ckpt_mask[i]) nblk[i]++;
            nblk[ckpt_dst]++;
        end
        if (rel_valid) for (int i = 0; i < N; i++) if (rel_mask[i]) nblk[i]--;
        if (st_block_valid)   nblk[st_block_preg]++;
        if (st_unblock_valid) nblk[st_unblock_preg]--;
        ok = !(alloc_valid && !mfree(alloc_preg));
        for (int i = 0; i < N; i++)
            if (nref[i] < 0 || nref[i] > CMAX || nblk[i] < 0 || nblk[i] > CMAX) ok = 0;
    endtask

    task automatic check_bit(string tag, int idx, bit exp);
        checks++;
        if (free_vec[idx] !== exp) begin
            failures++;
            $display("FAIL %s free_vec[%0d] actual=%0b expected=%0b", tag, idx, free_vec[idx], exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [N-1:0] ev; int lo; bit any;
        ev = '0; lo = 0; any = 0;
        for (int i = N - 1; i >= 0; i--) if (mfree(i)) begin ev[i] = 1'b1; lo = i; any = 1; end
        checks++;
        if (free_vec !== ev) begin
            failures++;
            $display("FAIL %s free_vec actual=%h expected=%h", tag, free_vec, ev);
        end
        checks++;
        if (free_any !== any || int'(free_lowest) != lo) begin
            failures++;
            $display("FAIL R12 (%s) any/lowest actual=%0b/%0d expected=%0b/%0d",
                     tag, free_any, free_lowest, any, lo);
        end
    endtask

    // Drive the staged inputs for one edge, update the model, check at the next falling edge.
    task automatic step(string tag);
        bit ok;
        predict(ok);
        if (!ok) begin idle_inputs(); predict(ok); end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            busy_m[i] = nbusy[i]; ref_m[i] = nref[i]; blk_m[i] = nblk[i];
        end
        @(negedge clk);
        idle_inputs();
        check_all(tag);
    endtask

    function automatic int pick_pos_ref();
        int s = $urandom % N;
        for (int k = 0; k < N; k++) if (ref_m[(s + k) % N] > 0) return (s + k) % N;
        return -1;
    endfunction

    task automatic random_cycle();
        int r;
        int s;
        if ($urandom % 3 == 0) begin
            s = $urandom % N;
            for (int k = 0; k < N; k++) if (mfree((s + k) % N)) begin
                alloc_valid = 1; alloc_preg = PW'((s + k) % N); break;
            end
        end
        if ($urandom % 2 == 0) begin
            cmt_valid = 1; cmt_virtual = $urandom % 2; cmt_dst = PW'($urandom % N);
            r = pick_pos_ref();
            if (r >= 0 && $urandom % 4 != 0) begin cmt_old_valid = 1; cmt_old_dst = PW'(r); end
            cmt_src0_valid = $urandom % 2; cmt_src0 = PW'($urandom % N);
            cmt_src1_valid = $urandom % 2; cmt_src1 = PW'($urandom % N);
        end
        if ($urandom % 2 == 0) begin
            r = pick_pos_ref();
            if (r >= 0) begin wb_valid = 1; wb_old_valid = 1; wb_old_dst = PW'(r); end
            r = pick_pos_ref();
            if (r >= 0 && r != int'(wb_old_dst)) begin wb_valid = 1; wb_src0_valid = 1; wb_src0 = PW'(r); end
        end
        if ($urandom % 8 == 0) begin
            ckpt_valid = 1; ckpt_dst = PW'($urandom % N);
            for (int i = 0; i < N; i++) ckpt_mask[i] = ($urandom % 6 == 0);
        end
        if ($urandom % 3 == 0) begin
            rel_valid = 1;
            for (int i = 0; i < N; i++) rel_mask[i] = (blk_m[i] > 0) && ($urandom % 2 == 0);
        end
        if ($urandom % 6 == 0) begin st_block_valid = 1; st_block_preg = PW'($urandom % N); end
        if ($urandom % 5 == 0) begin
            s = $urandom % N;
            for (int k = 0; k < N; k++) if (blk_m[(s + k) % N] > 0) begin
                st_unblock_valid = 1; st_unblock_preg = PW'((s + k) % N); break;
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        idle_inputs();
        for (int i = 0; i < N; i++) begin busy_m[i] = 0; ref_m[i] = 0; blk_m[i] = 0; end
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1");

        // R3: allocation marks p3 busy
        alloc_valid = 1; alloc_preg = 7'd3; step("R3");
        check_bit("R3", 3, 0);
        // R4: normal commit of p3 without a replaced mapping
        cmt_valid = 1; cmt_dst = 7'd3; step("R4");
        alloc_valid = 1; alloc_preg = 7'd4; step("R3");
        // R4: p4 replaces p3 -> p3 drops its reference and busy flag
        cmt_valid = 1; cmt_dst = 7'd4; cmt_old_valid = 1; cmt_old_dst = 7'd3; step("R4");
        check_bit("R4", 3, 1);
        check_bit("R4", 4, 0);
        // R5/R10: virtual commit, both sources p4 (+2), p4 replaced
        alloc_valid = 1; alloc_preg = 7'd6; step("R3");
        cmt_valid = 1; cmt_virtual = 1; cmt_dst = 7'd6; cmt_old_valid = 1; cmt_old_dst = 7'd4;
        cmt_src0_valid = 1; cmt_src0 = 7'd4; cmt_src1_valid = 1; cmt_src1 = 7'd4; step("R5");
        check_bit("R5", 4, 0);
        // R6: writeback releases old dest and one source; one reference remains
        wb_valid = 1; wb_old_valid = 1; wb_old_dst = 7'd4; wb_src0_valid = 1; wb_src0 = 7'd4; step("R6");
        check_bit("R6", 4, 0);
        wb_valid = 1; wb_src1_valid = 1; wb_src1 = 7'd4; step("R6");
        check_bit("R6", 4, 1);
        // R7/R10: checkpoint with dst also in the mask
        ckpt_valid = 1; ckpt_mask[10] = 1; ckpt_mask[11] = 1; ckpt_dst = 7'd10; step("R7");
        check_bit("R7", 10, 0);
        check_bit("R7", 11, 0);
        rel_valid = 1; rel_mask[10] = 1; rel_mask[11] = 1; step("R8");
        check_bit("R8", 11, 1);
        check_bit("R10", 10, 0);
        rel_valid = 1; rel_mask[10] = 1; step("R8");
        check_bit("R8", 10, 1);
        // R9: store pins and unpins p12
        st_block_valid = 1; st_block_preg = 7'd12; step("R9");
        check_bit("R9", 12, 0);
        st_unblock_valid = 1; st_unblock_preg = 7'd12; step("R9");
        check_bit("R9", 12, 1);
        // R11: reference count of p20 up to 15 and back
        for (int k = 0; k < CMAX; k++) begin cmt_valid = 1; cmt_virtual = 1; cmt_dst = 7'd20; step("R11"); end
        check_bit("R11", 20, 0);
        for (int k = 0; k < CMAX - 1; k++) begin wb_valid = 1; wb_src0_valid = 1; wb_src0 = 7'd20; step("R11"); end
        check_bit("R11", 20, 0);
        wb_valid = 1; wb_src0_valid = 1; wb_src0 = 7'd20; step("R11");
        check_bit("R11", 20, 1);
        // R12: lowest skips a busy p0; then nothing free
        alloc_valid = 1; alloc_preg = 7'd0; step("R12");
        checks++;
        if (free_lowest !== 7'd1) begin
            failures++; $display("FAIL R12 free_lowest actual=%0d expected=1", free_lowest);
        end
        ckpt_valid = 1; ckpt_mask = '1; ckpt_dst = 7'd0; step("R12");
        checks++;
        if (free_any !== 1'b0 || free_lowest !== '0) begin
            failures++; $display("FAIL R12 none-free actual=%0b/%0d expected=0/0", free_any, free_lowest);
        end
        rel_valid = 1; rel_mask = '1; step("R8");

        // R2: constrained random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            random_cycle();
            step("R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule